// File: doc/BRIEF.md
# Two-input event gate bank for hardware barriers

The block is a bank of small synchronisation engines, one bank per network interface. Each engine (a gate) is set up with the two events it expects and the two places it sends to once both have arrived. A destination is either another gate in the same bank or a gate on a remote node reached through the external event port. Chaining gates in this way lets software map any barrier algorithm onto the hardware, whether a recursive-doubling exchange or a reduce-broadcast tree. Gates are not a single shared counter.

The low-numbered gates double as barrier channels, which are the interface software uses. Channel `c` is bound for good to gate `c`, which is both the start and the end of that channel's barrier. An arm write counts as the gate's first input and sends its start event at once. The returning event completes the barrier and raises the channel's done flag, which software polls or takes as an interrupt. Gates that fire in the same cycle share a single round-robin delivery path, so their events leave one per cycle.

Event identifiers are `GID_W+1` bits wide. The top bit set means an external endpoint, whose low bits are the remote gate id. The top bit clear means a local gate, whose low bits are that gate's index.

Top module: `bgate_bank`

## Requirements
- R1: After reset every channel done flag, `irq`, `err` and `tx_valid` read 0, and every gate is disabled.
- R2: A non-channel gate fires only after it has received an event whose tag equals its source 0 and one whose tag equals its source 1, in either order. One of the two alone produces no outgoing event.
- R3: Firing clears both received flags. A later episode needs two fresh events, and a repeat of the same event does not fire the gate again.
- R4: An arm write to channel `c` sends gate `c`'s destination-0 event at once. With an external destination, `tx_valid` is high in the cycle after the second clock edge, counting the edge that samples the arm.
- R5: A channel's done flag is set on the edge that samples the matching return event (source 1), and `irq` is the OR of all done flags. A later arm write clears that done flag.
- R6: An event aimed at a disabled gate, or one whose tag matches no source slot of the gate, sets a sticky `err` and is dropped. The gate's collected state is unchanged and it still fires on the proper pair.
- R7: A local destination (top id bit 0) is delivered to the target gate with source tag `{0, sender index}`. Each hop takes two clock edges from a firing to a firing.
- R8: Pending outgoing events leave one per cycle through a round-robin arbiter. A gate with both destinations valid sends both, on consecutive cycles.
- R9: On an external send, `tx_gate` carries the low id bits of the destination and `tx_src` carries the sending gate index. An arriving `rx_src` is matched as the tag `{1, rx_src}`.
- R10: A configuration write to a gate clears its received flags and pending events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_gate | input | GID_W | Gate being configured |
| cfg_en | input | 1 | Gate enable |
| cfg_src0 | input | GID_W+1 | Expected tag for input slot 0 |
| cfg_src1 | input | GID_W+1 | Expected tag for input slot 1 |
| cfg_dst0 | input | GID_W+1 | Destination 0 identifier |
| cfg_dst1 | input | GID_W+1 | Destination 1 identifier |
| cfg_dv0 | input | 1 | Destination 0 in use |
| cfg_dv1 | input | 1 | Destination 1 in use |
| arm_valid | input | 1 | Software arm write |
| arm_ch | input | CH_W | Channel armed |
| rx_valid | input | 1 | External event arrives |
| rx_gate | input | GID_W | Local gate addressed |
| rx_src | input | GID_W | Remote gate that sent it |
| tx_valid | output | 1 | External event sent |
| tx_gate | output | GID_W | Remote gate addressed |
| tx_src | output | GID_W | Local gate sending |
| ch_done | output | NUM_CH | Per-channel completion flags |
| irq | output | 1 | Any channel complete |
| err | output | 1 | Sticky misdirected-event flag |

## Verification
An event that completes a gate is sampled on edge E. The pending event is granted in the following cycle, so `tx_valid` or the internal delivery register is visible after edge E+1. A local target therefore fires at edge E+2, and done flags and `err` change on the very edge that samples their cause. The bench drives each stimulus for one cycle between falling edges and then waits exactly this many falling edges before sampling. It checks both the absence of an output one hop early and its presence at the due cycle. Ordering is swept over every non-channel gate of an eight-gate bank, with both arrival orders each.

// File: rtl/bgate_bank.sv
module bgate_bank #(
  parameter int NUM_GATES = 48,
  parameter int NUM_CH    = 16,
  localparam int GID_W = $clog2(NUM_GATES),
  localparam int ID_W  = GID_W + 1,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [GID_W-1:0] cfg_gate,
  input  logic             cfg_en,
  input  logic [ID_W-1:0]  cfg_src0,
  input  logic [ID_W-1:0]  cfg_src1,
  input  logic [ID_W-1:0]  cfg_dst0,
  input  logic [ID_W-1:0]  cfg_dst1,
  input  logic             cfg_dv0,
  input  logic             cfg_dv1,
  input  logic             arm_valid,
  input  logic [CH_W-1:0]  arm_ch,
  input  logic             rx_valid,
  input  logic [GID_W-1:0] rx_gate,
  input  logic [GID_W-1:0] rx_src,
  output logic             tx_valid,
  output logic [GID_W-1:0] tx_gate,
  output logic [GID_W-1:0] tx_src,
  output logic [NUM_CH-1:0] ch_done,
  output logic             irq,
  output logic             err
);
  localparam int NREQ = 2 * NUM_GATES;
  localparam int RQ_W = $clog2(NREQ);

  logic [NUM_GATES-1:0] en_q, dv0_q, dv1_q, f0_q, f1_q, p0_q, p1_q;
  logic [ID_W-1:0] s0_q [NUM_GATES];
  logic [ID_W-1:0] s1_q [NUM_GATES];
  logic [ID_W-1:0] d0_q [NUM_GATES];
  logic [ID_W-1:0] d1_q [NUM_GATES];

  logic             iv_q;
  logic [GID_W-1:0] ig_q, is_q;
  logic [RQ_W-1:0]  ptr_q;

  logic [NUM_GATES-1:0] fire_v, bad_v, nf0, nf1, np0, np1;
  logic [NUM_CH-1:0]    done_n;
  logic [NREQ-1:0]      req;
  logic                 gnt_any;
  logic [RQ_W-1:0]      gnt_idx;
  logic [GID_W-1:0]     gsel;
  logic [ID_W-1:0]      gdst;

  wire [ID_W-1:0] rx_tag = {1'b1, rx_src};
  wire [ID_W-1:0] in_tag = {1'b0, is_q};

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    localparam bit IS_CH = (g < NUM_CH);
    logic rx_h, in_h, arm_h, m0, m1, ok_rx, ok_in, a0, a1, n0, n1, wr, gn0, gn1;

    assign rx_h = rx_valid && rx_gate == GID_W'(g);
    assign in_h = iv_q && ig_q == GID_W'(g);
    if (IS_CH) begin : g_arm
      assign arm_h = arm_valid && arm_ch == CH_W'(g);
      assign done_n[g] = arm_h ? fire_v[g] : (ch_done[g] | fire_v[g]);
    end else begin : g_noarm
      assign arm_h = 1'b0;
    end

    assign m0 = IS_CH ? arm_h
                      : ((rx_h && rx_tag == s0_q[g]) || (in_h && in_tag == s0_q[g]));
    assign m1 = (rx_h && rx_tag == s1_q[g]) || (in_h && in_tag == s1_q[g]);
    assign ok_rx = (rx_tag == s1_q[g]) || (!IS_CH && rx_tag == s0_q[g]);
    assign ok_in = (in_tag == s1_q[g]) || (!IS_CH && in_tag == s0_q[g]);
    assign bad_v[g] = en_q[g] ? ((rx_h && !ok_rx) || (in_h && !ok_in))
                              : (rx_h || in_h || arm_h);

    assign a0 = en_q[g] && m0;
    assign a1 = en_q[g] && m1;
    assign n0 = f0_q[g] || a0;
    assign n1 = f1_q[g] || a1;
    assign fire_v[g] = en_q[g] && n0 && n1;
    assign wr = cfg_we && cfg_gate == GID_W'(g);

    assign gn0 = gnt_any && gnt_idx == RQ_W'(2 * g);
    assign gn1 = gnt_any && gnt_idx == RQ_W'(2 * g + 1);
    assign nf0[g] = !wr && !fire_v[g] && n0;
    assign nf1[g] = !wr && !fire_v[g] && n1;
    assign np0[g] = !wr && ((p0_q[g] && !gn0) || ((IS_CH ? a0 : fire_v[g]) && dv0_q[g]));
    assign np1[g] = !wr && ((p1_q[g] && !gn1) || (fire_v[g] && dv1_q[g]));

    assign req[2*g]   = p0_q[g];
    assign req[2*g+1] = p1_q[g];
  end

  always_comb begin
    int j;
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int i = NREQ; i >= 1; i--) begin
      j = int'(ptr_q) + i;
      if (j >= NREQ) j = j - NREQ;
      if (req[j]) begin
        gnt_any = 1'b1;
        gnt_idx = RQ_W'(j);
      end
    end
  end

  assign gsel = gnt_idx[RQ_W-1:1];
  assign gdst = gnt_idx[0] ? d1_q[gsel] : d0_q[gsel];
  assign irq  = |ch_done;

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      s0_q[cfg_gate] <= cfg_src0;
      s1_q[cfg_gate] <= cfg_src1;
      d0_q[cfg_gate] <= cfg_dst0;
      d1_q[cfg_gate] <= cfg_dst1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; dv0_q <= '0; dv1_q <= '0;
      f0_q <= '0; f1_q <= '0; p0_q <= '0; p1_q <= '0;
      iv_q <= 1'b0; ig_q <= '0; is_q <= '0; ptr_q <= '0;
      tx_valid <= 1'b0; tx_gate <= '0; tx_src <= '0;
      ch_done <= '0; err <= 1'b0;
    end else begin
      if (cfg_we) begin
        en_q[cfg_gate]  <= cfg_en;
        dv0_q[cfg_gate] <= cfg_dv0;
        dv1_q[cfg_gate] <= cfg_dv1;
      end
      f0_q <= nf0; f1_q <= nf1;
      p0_q <= np0; p1_q <= np1;
      if (gnt_any) ptr_q <= gnt_idx;
      iv_q     <= gnt_any && !gdst[GID_W];
      ig_q     <= gdst[GID_W-1:0];
      is_q     <= gsel;
      tx_valid <= gnt_any && gdst[GID_W];
      tx_gate  <= gdst[GID_W-1:0];
      tx_src   <= gsel;
      ch_done  <= done_n;
      err <= err || (|bad_v) || (iv_q && int'(ig_q) >= NUM_GATES)
                 || (rx_valid && int'(rx_gate) >= NUM_GATES)
                 || (arm_valid && int'(arm_ch) >= NUM_CH);
    end
  end
endmodule

// File: rtl/bgate_bank_chk.sv
module bgate_bank_chk #(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_valid,
  input logic [CH_W-1:0]   arm_ch,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic [NUM_CH-1:0] ch_done,
  input logic              err,
  input logic              iv_q
);
  // R8: the shared delivery path carries one event per cycle
  p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && iv_q));

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R5: a done flag only rises after an incoming event
  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_done & ~$past(ch_done)) != '0) |-> $past(rx_valid || iv_q));

  // R5: arming channel 0 with no event in flight leaves it not done
  p_arm_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_valid && arm_ch == '0 && !rx_valid && !iv_q) |=> !ch_done[0]);
endmodule

bind bgate_bank bgate_bank_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_bgate_bank.sv
module test_bgate_bank;
  localparam int CLK_PERIOD = 10;
  localparam int G = 8;
  localparam int CH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, cfg_dv0 = 0, cfg_dv1 = 0;
  logic [2:0] cfg_gate = 0;
  logic [3:0] cfg_src0 = 0, cfg_src1 = 0, cfg_dst0 = 0, cfg_dst1 = 0;
  logic arm_valid = 0;
  logic [0:0] arm_ch = 0;
  logic rx_valid = 0;
  logic [2:0] rx_gate = 0, rx_src = 0;
  logic tx_valid, irq, err;
  logic [2:0] tx_gate, tx_src;
  logic [CH-1:0] ch_done;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bgate_bank #(.NUM_GATES(G), .NUM_CH(CH)) i_bgate_bank (
    .clk, .rst_n, .cfg_we, .cfg_gate, .cfg_en, .cfg_src0, .cfg_src1,
    .cfg_dst0, .cfg_dst1, .cfg_dv0, .cfg_dv1, .arm_valid, .arm_ch,
    .rx_valid, .rx_gate, .rx_src, .tx_valid, .tx_gate, .tx_src,
    .ch_done, .irq, .err);

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_wr(int g, int s0, int s1, int d0, int d1, bit v0, bit v1);
    cfg_we = 1; cfg_gate = 3'(g); cfg_en = 1;
    cfg_src0 = 4'(s0); cfg_src1 = 4'(s1); cfg_dst0 = 4'(d0); cfg_dst1 = 4'(d1);
    cfg_dv0 = v0; cfg_dv1 = v1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ev(int g, int src);
    rx_valid = 1; rx_gate = 3'(g); rx_src = 3'(src);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic arm(int c);
    arm_valid = 1; arm_ch = 1'(c);
    @(negedge clk);
    arm_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int a, b;
    do_reset();
    // R1
    check("R1", "ch_done", int'(ch_done), 0);
    check("R1", "irq", int'(irq), 0);
    check("R1", "err", int'(err), 0);
    check("R1", "tx_valid", int'(tx_valid), 0);

    // R2/R3/R9 sweep over every non-channel gate and both orders
    for (int g = CH; g < G; g++) begin
      for (int ord = 0; ord < 2; ord++) begin
        cfg_wr(g, 8 | g, 8 | ((g + 3) % G), 8 | ((g + 2) % G), 0, 1, 0);
        a = ord ? (g + 3) % G : g;
        b = ord ? g : (g + 3) % G;
        ev(g, a);
        @(negedge clk);
        check("R2", "tx after one event", int'(tx_valid), 0);
        ev(g, b);
        @(negedge clk);
        check("R2", "tx after pair", int'(tx_valid), 1);
        check("R9", "tx_gate", int'(tx_gate), (g + 2) % G);
        check("R9", "tx_src", int'(tx_src), g);
        if (ord == 0) begin
          ev(g, b);
          @(negedge clk);
          check("R3", "repeat alone", int'(tx_valid), 0);
          ev(g, a);
          @(negedge clk);
          check("R3", "second episode", int'(tx_valid), 1);
        end
      end
    end

    // R8: both destinations, consecutive cycles
    cfg_wr(2, 8 | 1, 8 | 2, 8 | 5, 8 | 6, 1, 1);
    ev(2, 1);
    ev(2, 2);
    @(negedge clk);
    check("R8", "first send", int'(tx_valid), 1);
    a = int'(tx_gate);
    @(negedge clk);
    check("R8", "second send", int'(tx_valid), 1);
    b = int'(tx_gate);
    check("R8", "both ids", int'((a == 5 && b == 6) || (a == 6 && b == 5)), 1);
    @(negedge clk);
    check("R8", "no third send", int'(tx_valid), 0);

    // R4/R5: channel 0 with external partner
    cfg_wr(0, 0, 8 | 4, 8 | 3, 0, 1, 0);
    arm(0);
    check("R5", "not done after arm", int'(ch_done[0]), 0);
    @(negedge clk);
    check("R4", "start tx", int'(tx_valid), 1);
    check("R4", "start tx_gate", int'(tx_gate), 3);
    check("R4", "start tx_src", int'(tx_src), 0);
    ev(0, 4);
    check("R5", "done", int'(ch_done[0]), 1);
    check("R5", "irq", int'(irq), 1);
    check("R5", "no tx on completion", int'(tx_valid), 0);
    arm(0);
    check("R5", "rearm clears done", int'(ch_done[0]), 0);
    @(negedge clk);
    check("R4", "rearm start tx", int'(tx_valid), 1);

    // R7: channel 1 routed through local gate 5
    cfg_wr(1, 0, 5, 5, 0, 1, 0);
    cfg_wr(5, 1, 8 | 7, 1, 0, 1, 0);
    arm(1);
    repeat (3) @(negedge clk);
    check("R7", "no external tx", int'(tx_valid), 0);
    check("R7", "ch1 not done early", int'(ch_done[1]), 0);
    ev(5, 7);
    @(negedge clk);
    check("R7", "ch1 one edge short", int'(ch_done[1]), 0);
    @(negedge clk);
    check("R7", "ch1 done after hop", int'(ch_done[1]), 1);

    // R10: configuration write clears collected state
    cfg_wr(6, 8 | 1, 8 | 2, 8 | 3, 0, 1, 0);
    ev(6, 1);
    cfg_wr(6, 8 | 1, 8 | 2, 8 | 3, 0, 1, 0);
    ev(6, 2);
    @(negedge clk);
    check("R10", "no fire after rewrite", int'(tx_valid), 0);
    ev(6, 1);
    @(negedge clk);
    check("R10", "fires on fresh pair", int'(tx_valid), 1);
    check("R6", "err clean so far", int'(err), 0);

    // R6: misdirected events
    do_reset();
    ev(7, 0);
    check("R6", "err on disabled gate", int'(err), 1);
    @(negedge clk);
    check("R6", "no tx from disabled", int'(tx_valid), 0);
    do_reset();
    cfg_wr(4, 8 | 1, 8 | 2, 8 | 3, 0, 1, 0);
    ev(4, 1);
    ev(4, 6);
    check("R6", "err on unmatched", int'(err), 1);
    @(negedge clk);
    check("R6", "unmatched dropped", int'(tx_valid), 0);
    ev(4, 2);
    @(negedge clk);
    check("R6", "fires on proper pair", int'(tx_valid), 1);
    check("R6", "err sticky", int'(err), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule